// File: doc/BRIEF.md
# Next-PC Unit with Fault Vectoring

This block owns the program counter of a single-cycle processor and picks the address of the following instruction. Each cycle it sees an instruction class code from the decoder, along with the immediate, the value of the first register operand and the branch-taken flag. From these it forms the next address and presents it combinationally. When the valid strobe is high, it loads that address into the program counter at the clock edge.

Two instruction classes also change architectural exception state. A multiply has no hardware datapath, so it is handled as a fault. It counts as completed: the unit saves the address after it as the return address, writes the multiply cause code, switches to privileged mode with interrupts disabled, and vectors to a fixed handler address. The handler software uses the cause code as a byte offset into its jump table. A return-from-exception jumps to the saved return address, drops back to user mode and re-enables interrupts. The decoder raises the multiply class for function field 6'b011000 and the return class for rs field 5'b10000. This unit sees only the class code that results.

Top module: `npc_unit`

## Requirements
- R1: While reset is high and after it drops, pc_o is 0, epc_o is 0, cause_o is 0, priv_o is 1 (privileged) and irq_en_o is 0.
- R2: Class codes 0 (unsupported), 1 (ALU), 2 (load), 3 (store), and every code from 9 to 15, select pc_o+4.
- R3: Class code 4 (direct jump) selects {bits [31:28] of pc_o+4, bits [27:0] of imm_i}.
- R4: Class code 5 (register jump) selects rval_i.
- R5: Class code 6 (branch) selects pc_o+4+imm_i when taken_i is 1 and pc_o+4 when taken_i is 0.
- R6: Class code 7 (multiply fault) selects 0x1004. With valid_i high it loads epc_o with the old pc_o+4, cause_o with 0, priv_o with 1 and irq_en_o with 0.
- R7: Class code 8 (return from exception) selects the current epc_o. With valid_i high it sets priv_o to 0 and irq_en_o to 1 and leaves epc_o unchanged.
- R8: While valid_i is low, pc_o, epc_o, cause_o, priv_o and irq_en_o keep their values at the next edge.
- R9: When valid_i is high, pc_o takes at the next edge the value next_pc_o showed before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction valid; gates every register update |
| itype_i | input | 4 | Instruction class code |
| imm_i | input | 32 | Decoded immediate |
| rval_i | input | 32 | First register operand value |
| taken_i | input | 1 | Branch condition result |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Selected next address (combinational) |
| epc_o | output | 32 | Saved return address |
| cause_o | output | 8 | Fault cause code |
| priv_o | output | 1 | 1 = privileged mode, 0 = user mode |
| irq_en_o | output | 1 | Interrupt enable |

## Verification
A corrupted return address stays hidden until the next return-from-exception. At that point next_pc_o shows it in the same cycle, and pc_o shows it one edge later. For that reason the sweep follows every fault with a return. A wrong target for any class shows on next_pc_o before the edge, and on pc_o right after it. A stuck mode or interrupt-enable bit shows on priv_o and irq_en_o one edge after the fault or return that should have flipped it. A valid strobe that leaks shows as a pc_o change on a cycle with valid_i low.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  localparam int ITYPE_W = 4;

  typedef enum logic [ITYPE_W-1:0] {
    IT_UNSUP  = 4'd0,
    IT_ALU    = 4'd1,
    IT_LOAD   = 4'd2,
    IT_STORE  = 4'd3,
    IT_JUMP   = 4'd4,
    IT_JREG   = 4'd5,
    IT_BRANCH = 4'd6,
    IT_MULT   = 4'd7,
    IT_ERET   = 4'd8
  } itype_e;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_PRIV = 1'b1
  } mode_e;
endpackage

// File: rtl/npc_target.sv
`timescale 1ns/1ps
module npc_target #(
  parameter int          XLEN         = 32,
  parameter int          REGION_W     = 4,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h0000_1004
) (
  input  logic [XLEN-1:0]             pc_i,
  input  logic [npc_pkg::ITYPE_W-1:0] itype_i,
  input  logic [XLEN-1:0]             imm_i,
  input  logic [XLEN-1:0]             rval_i,
  input  logic                        taken_i,
  input  logic [XLEN-1:0]             epc_i,
  output logic [XLEN-1:0]             target_o,
  output logic                        fault_o,
  output logic                        ret_o
);
  localparam int LOW_W = XLEN - REGION_W;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] jump_pc;
  logic [XLEN-1:0] br_pc;

  assign seq_pc  = pc_i + XLEN'(4);
  assign jump_pc = {seq_pc[XLEN-1 -: REGION_W], imm_i[LOW_W-1:0]};
  assign br_pc   = taken_i ? (seq_pc + imm_i) : seq_pc;

  always_comb begin
    target_o = seq_pc;
    fault_o  = 1'b0;
    ret_o    = 1'b0;
    unique case (itype_i)
      npc_pkg::IT_JUMP:   target_o = jump_pc;
      npc_pkg::IT_JREG:   target_o = rval_i;
      npc_pkg::IT_BRANCH: target_o = br_pc;
      npc_pkg::IT_MULT: begin
        target_o = HANDLER_ADDR;
        fault_o  = 1'b1;
      end
      npc_pkg::IT_ERET: begin
        target_o = epc_i;
        ret_o    = 1'b1;
      end
      default:            target_o = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_excp_state.sv
`timescale 1ns/1ps
module npc_excp_state #(
  parameter int               XLEN       = 32,
  parameter int               CAUSE_W    = 8,
  parameter logic [CAUSE_W-1:0] MULT_CAUSE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic               fault_i,
  input  logic               ret_i,
  input  logic [XLEN-1:0]    ret_addr_i,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               priv_o,
  output logic               irq_en_o
);
  npc_pkg::mode_e mode_q;
  logic [XLEN-1:0]    epc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               irq_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q    <= '0;
      cause_q  <= '0;
      mode_q   <= npc_pkg::MODE_PRIV;
      irq_en_q <= 1'b0;
    end else if (valid_i) begin
      if (fault_i) begin
        epc_q    <= ret_addr_i;
        cause_q  <= MULT_CAUSE;
        mode_q   <= npc_pkg::MODE_PRIV;
        irq_en_q <= 1'b0;
      end else if (ret_i) begin
        mode_q   <= npc_pkg::MODE_USER;
        irq_en_q <= 1'b1;
      end
    end
  end

  assign epc_o    = epc_q;
  assign cause_o  = cause_q;
  assign priv_o   = (mode_q == npc_pkg::MODE_PRIV);
  assign irq_en_o = irq_en_q;

  // R7: a return leaves the saved address untouched
  p_ret_keeps_epc_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ret_i && !fault_i) |=> $stable(epc_o));
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit #(
  parameter int                 XLEN         = 32,
  parameter int                 CAUSE_W      = 8,
  parameter logic [XLEN-1:0]    HANDLER_ADDR = 32'h0000_1004,
  parameter logic [XLEN-1:0]    RESET_PC     = '0,
  parameter logic [CAUSE_W-1:0] MULT_CAUSE   = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid_i,
  input  logic [npc_pkg::ITYPE_W-1:0] itype_i,
  input  logic [XLEN-1:0]             imm_i,
  input  logic [XLEN-1:0]             rval_i,
  input  logic                        taken_i,
  output logic [XLEN-1:0]             pc_o,
  output logic [XLEN-1:0]             next_pc_o,
  output logic [XLEN-1:0]             epc_o,
  output logic [CAUSE_W-1:0]          cause_o,
  output logic                        priv_o,
  output logic                        irq_en_o
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] target;
  logic            is_fault;
  logic            is_ret;

  npc_target #(
    .XLEN         (XLEN),
    .REGION_W     (4),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_target (
    .pc_i     (pc_q),
    .itype_i  (itype_i),
    .imm_i    (imm_i),
    .rval_i   (rval_i),
    .taken_i  (taken_i),
    .epc_i    (epc_o),
    .target_o (target),
    .fault_o  (is_fault),
    .ret_o    (is_ret)
  );

  npc_excp_state #(
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W),
    .MULT_CAUSE (MULT_CAUSE)
  ) u_excp (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .fault_i    (is_fault),
    .ret_i      (is_ret),
    .ret_addr_i (pc_q + XLEN'(4)),
    .epc_o      (epc_o),
    .cause_o    (cause_o),
    .priv_o     (priv_o),
    .irq_en_o   (irq_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= RESET_PC;
    else if (valid_i) pc_q <= target;
  end

  assign pc_o      = pc_q;
  assign next_pc_o = target;

  // R8: no architectural change without the strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(pc_o) && $stable(epc_o) && $stable(cause_o)
                  && $stable(priv_o) && $stable(irq_en_o)));

  // R6: fault vectors and saves the completed instruction's successor
  p_fault_vector_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && itype_i == npc_pkg::IT_MULT) |=>
      (pc_o == HANDLER_ADDR && epc_o == $past(pc_o) + XLEN'(4)
       && cause_o == MULT_CAUSE && priv_o && !irq_en_o));

  // R7: return goes to the saved address in user mode
  p_eret_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && itype_i == npc_pkg::IT_ERET) |=>
      (pc_o == $past(epc_o) && !priv_o && irq_en_o));

  // R9: the register follows the presented target
  p_follow_r9: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (pc_o == $past(next_pc_o)));
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [3:0]  itype_i = '0;
  logic [31:0] imm_i = '0;
  logic [31:0] rval_i = '0;
  logic        taken_i = 1'b0;
  logic [31:0] pc_o, next_pc_o, epc_o;
  logic [7:0]  cause_o;
  logic        priv_o, irq_en_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_pc, m_epc;
  logic        m_priv, m_irq;

  always #4 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .itype_i(itype_i),
    .imm_i(imm_i), .rval_i(rval_i), .taken_i(taken_i),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .epc_o(epc_o),
    .cause_o(cause_o), .priv_o(priv_o), .irq_en_o(irq_en_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check({req, " pc"},    pc_o,            m_pc);
    check({req, " epc"},   epc_o,           m_epc);
    check({req, " cause"}, 32'(cause_o),    32'd0);
    check({req, " priv"},  32'(priv_o),     32'(m_priv));
    check({req, " irq"},   32'(irq_en_o),   32'(m_irq));
  endtask

  task automatic model_reset();
    m_pc = '0; m_epc = '0; m_priv = 1'b1; m_irq = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b0;
    @(posedge clk); #2;
    model_reset();
    check_state("R1 during reset");
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check_state("R1 after reset");
  endtask

  task automatic step(logic [3:0] code, logic [31:0] imm, logic [31:0] rv,
                      logic tk, logic vld);
    logic [31:0] pc4, exp;
    string req;
    @(negedge clk);
    itype_i = code; imm_i = imm; rval_i = rv; taken_i = tk; valid_i = vld;
    #1;
    pc4 = m_pc + 32'd4;
    case (code)
      4'd4: begin exp = {pc4[31:28], imm[27:0]}; req = "R3"; end
      4'd5: begin exp = rv; req = "R4"; end
      4'd6: begin exp = tk ? pc4 + imm : pc4; req = "R5"; end
      4'd7: begin exp = 32'h0000_1004; req = "R6"; end
      4'd8: begin exp = m_epc; req = "R7"; end
      default: begin exp = pc4; req = "R2"; end
    endcase
    check({req, " next_pc"}, next_pc_o, exp);
    if (vld) begin
      m_pc = exp;
      if (code == 4'd7) begin m_epc = pc4; m_priv = 1'b1; m_irq = 1'b0; end
      if (code == 4'd8) begin m_priv = 1'b0; m_irq = 1'b1; end
    end
    @(posedge clk); #2;
    // R9: registered pc equals presented target; R8 when strobe is low
    check_state(vld ? {req, "/R9"} : "R8");
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] imms [4];
    imms[0] = 32'h0000_0010;
    imms[1] = 32'hFFFF_FFF8;
    imms[2] = 32'h0ABC_DEF0;
    imms[3] = 32'hF234_5678;
    model_reset();
    do_reset();
    for (int c = 0; c < 16; c++) begin
      for (int t = 0; t < 2; t++) begin
        for (int k = 0; k < 4; k++) begin
          step(4'(c), imms[k], 32'h0000_2000 + 32'(c * 64 + t * 16 + k * 4),
               t[0], 1'b1);
          step(4'd8, imms[k], 32'h0, 1'b0, 1'b0);
          step(4'(c), imms[k], 32'h5555_0000, t[0], 1'b0);
        end
      end
    end
    // fault then return: resumes after the faulting instruction
    for (int n = 0; n < 8; n++) begin
      step(4'd5, '0, 32'h0000_4000 + 32'(n * 256), 1'b0, 1'b1);
      step(4'd1, '0, '0, 1'b0, 1'b1);
      step(4'd7, '0, '0, 1'b0, 1'b1);
      step(4'd2, '0, '0, 1'b0, 1'b1);
      step(4'd6, 32'h0000_0020, '0, 1'b1, 1'b1);
      step(4'd8, '0, '0, 1'b0, 1'b1);
    end
    // fault while already in handler overwrites return address (R6)
    step(4'd7, '0, '0, 1'b0, 1'b1);
    step(4'd7, '0, '0, 1'b0, 1'b1);
    step(4'd8, '0, '0, 1'b0, 1'b1);
    // reset mid-run restores R1 state
    do_reset();
    step(4'd8, '0, '0, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule